// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block sits between a trace writer that streams into a buffer of consecutive addresses and the memory system. When translation is on, it maps each request address to a physical address through a chain of 4 KB tables held in memory. Each table covers 1 MB of input space and is joined to its neighbours by a previous link and a next link. When translation is off, addresses go through unchanged and no table is touched.

A request is taken with a valid/ready handshake and gets exactly one response: a translated address or a fault. Table entries are 64 bits wide. Bit 0 is the valid flag, and the page address is held in the bits from 12 upward. The unit remembers the table it last stood on and the last page it translated. A request in that same page costs no memory read. A request in the table just before or just after the current one costs one link read. Any other jump restarts from the table base and steps forward along the next links. Entries are fetched through a simple read port that accepts any latency.

Top module: `chain_xlate`

## Requirements
- R1: With `cfg_translate` low, an accepted request is answered on the next cycle with `rsp_addr` equal to `req_addr` and no fault, even below the input base, and no memory read is issued.
- R2: In translate mode, with offset = `req_addr` − `cfg_in_base`, the table number is offset[AW-1:20] and the entry index is offset[19:12]. The entry is read at table address + 8 × index. The response is entry[AW-1:12] joined with offset[11:0], and entry bits 11:1 play no part in it.
- R3: A data entry whose bit 0 is clear answers the request with a fault.
- R4: When the target table is one above the current table, the walk reads the next link at byte 0xFF8 of the current table. When it is one below, the walk reads the previous link at byte 0xFF0. A valid link becomes the new current table.
- R5: With no current table, or with a target more than one table away, the walk restarts at `cfg_table_base` as table 0 without a memory read, then follows next links forward until it reaches the target.
- R6: A link with bit 0 clear ends the walk with a fault, and the current table stays where it was.
- R7: In translate mode, a request below `cfg_in_base` faults on the next cycle with no memory read.
- R8: A request in the same 4 KB input page as the last successful translation is answered on the next cycle with no memory read.
- R9: `fault_sticky` sets with every fault response and holds while `cfg_enable` is high. It clears in a cycle where `cfg_enable` is low and no fault is being reported.
- R10: `status_ready` is low for the whole of a table walk. `req_ready` is high only when `cfg_enable` and `status_ready` are both high.
- R11: Each memory read is a one-cycle `mem_req` pulse with an 8-byte-aligned `mem_addr`. The walker waits for `mem_rvalid` for any number of cycles.
- R12: Clearing `cfg_enable` while idle drops both the cached page and the current table, so the next translation restarts from the table base.
- R13: Every accepted request produces exactly one `rsp_valid` pulse. A faulting request is consumed and is not retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Unit enable |
| cfg_translate | input | 1 | 1 = translate through tables, 0 = pass addresses through |
| cfg_table_base | input | AW | Physical address of table 0 (4 KB aligned) |
| cfg_in_base | input | AW | Input address that maps to entry 0 of table 0 (1 MB aligned) |
| status_ready | output | 1 | Unit idle, no walk in progress |
| fault_sticky | output | 1 | Sticky fault flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | AW | Input address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | AW | Translated or forwarded address |
| rsp_fault | output | 1 | Response is a fault |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | AW | Table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry read |

## Verification
A corrupted current-table number or table address does not show up on the request that caused it. It shows up on a later request, as the wrong number of `mem_req` pulses between acceptance and response, or as a response address taken from another table. For this reason the reference model counts reads per request, and the test order moves up and down the chain before it jumps. A stale cached page shows up at once as a next-cycle response with no read where a walk was due, which is why re-enable is followed by a request to the previously cached page. Sticky-flag faults show up at the response cycle itself.

// File: rtl/cx_pkg.sv
`timescale 1ns/1ps
package cx_pkg;
  localparam int unsigned PG_SH  = 12;             // 4 KB pages and tables
  localparam int unsigned TBL_SH = 20;             // 1 MB per table
  localparam int unsigned IDX_W  = TBL_SH - PG_SH; // data slots index width
  localparam int unsigned SLOT_W = PG_SH - 3;      // 64-bit slots per table
  localparam logic [SLOT_W-1:0] SLOT_PREV = SLOT_W'(510);
  localparam logic [SLOT_W-1:0] SLOT_NEXT = SLOT_W'(511);

  typedef enum logic [1:0] {W_IDLE, W_STEP, W_ENT, W_LINK} walk_st_e;

  // byte offset of a slot within its table
  function automatic logic [PG_SH-1:0] slot_byte(input logic [SLOT_W-1:0] slot);
    return {slot, 3'b000};
  endfunction

  // data pointers live in the lower half of the table
  function automatic logic [SLOT_W-1:0] data_slot(input logic [IDX_W-1:0] idx);
    return {1'b0, idx};
  endfunction

  function automatic logic entry_ok(input logic [63:0] ent);
    return ent[0];
  endfunction
endpackage

// File: rtl/cx_page_cache.sv
`timescale 1ns/1ps
module cx_page_cache #(
  parameter int unsigned PW = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] look_pn,
  output logic          hit,
  output logic [PW-1:0] hit_pg,
  input  logic          fill,
  input  logic [PW-1:0] fill_pn,
  input  logic [PW-1:0] fill_pg
);
  logic          held_v;
  logic [PW-1:0] held_pn;
  logic [PW-1:0] held_pg;

  assign hit    = held_v && (look_pn == held_pn);
  assign hit_pg = held_pg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v  <= 1'b0;
      held_pn <= '0;
      held_pg <= '0;
    end else if (!en) begin
      held_v <= 1'b0;
    end else if (fill) begin
      held_v  <= 1'b1;
      held_pn <= fill_pn;
      held_pg <= fill_pg;
    end
  end
endmodule

// File: rtl/cx_walker.sv
`timescale 1ns/1ps
module cx_walker
  import cx_pkg::*;
#(
  parameter int unsigned AW = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 start,
  input  logic [AW-TBL_SH-1:0] tgt_tbl,
  input  logic [IDX_W-1:0]     tgt_idx,
  input  logic [AW-1:0]        tbl_base,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_rvalid,
  input  logic [63:0]          mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 done_fault,
  output logic [AW-PG_SH-1:0]  done_page
);
  localparam int unsigned TW = AW - TBL_SH;
  localparam int unsigned PW = AW - PG_SH;
  localparam logic [TW-1:0] T_ONE = TW'(1);

  walk_st_e      st;
  logic          cur_v;
  logic          fwd_ok;
  logic          dir_up;
  logic [TW-1:0] cur_tbl;
  logic [TW-1:0] want_tbl;
  logic [PW-1:0] cur_pg;
  logic [IDX_W-1:0] want_idx;
  logic          on_target, go_next, go_prev, rd_ok;
  logic          unused_rd;

  assign unused_rd = ^{mem_rdata[63:AW], mem_rdata[PG_SH-1:1], tbl_base[PG_SH-1:0]};

  assign on_target = cur_v && (want_tbl == cur_tbl);
  assign go_next   = cur_v && ((want_tbl == cur_tbl + T_ONE) ||
                               (fwd_ok && (want_tbl > cur_tbl)));
  assign go_prev   = cur_v && (want_tbl + T_ONE == cur_tbl);
  assign rd_ok     = entry_ok(mem_rdata);

  assign busy       = (st != W_IDLE);
  assign done       = mem_rvalid && ((st == W_ENT) || ((st == W_LINK) && !rd_ok));
  assign done_fault = (st == W_LINK) || !rd_ok;
  assign done_page  = mem_rdata[AW-1:PG_SH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cur_v    <= 1'b0;
      fwd_ok   <= 1'b0;
      dir_up   <= 1'b0;
      cur_tbl  <= '0;
      want_tbl <= '0;
      cur_pg   <= '0;
      want_idx <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (!en) cur_v <= 1'b0;
          if (start) begin
            st       <= W_STEP;
            want_tbl <= tgt_tbl;
            want_idx <= tgt_idx;
            fwd_ok   <= 1'b0;
          end
        end
        W_STEP: begin
          if (on_target) begin
            mem_req  <= 1'b1;
            mem_addr <= {cur_pg, slot_byte(data_slot(want_idx))};
            st       <= W_ENT;
          end else if (go_next) begin
            mem_req  <= 1'b1;
            mem_addr <= {cur_pg, slot_byte(SLOT_NEXT)};
            dir_up   <= 1'b1;
            st       <= W_LINK;
          end else if (go_prev) begin
            mem_req  <= 1'b1;
            mem_addr <= {cur_pg, slot_byte(SLOT_PREV)};
            dir_up   <= 1'b0;
            st       <= W_LINK;
          end else begin
            cur_v   <= 1'b1;
            cur_tbl <= '0;
            cur_pg  <= tbl_base[AW-1:PG_SH];
            fwd_ok  <= 1'b1;
          end
        end
        W_ENT: begin
          if (mem_rvalid) st <= W_IDLE;
        end
        W_LINK: begin
          if (mem_rvalid) begin
            if (rd_ok) begin
              cur_pg  <= mem_rdata[AW-1:PG_SH];
              cur_tbl <= dir_up ? cur_tbl + T_ONE : cur_tbl - T_ONE;
              st      <= W_STEP;
            end else begin
              st <= W_IDLE;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_xlate.sv
`timescale 1ns/1ps
module chain_xlate
  import cx_pkg::*;
#(
  parameter int unsigned AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_translate,
  input  logic [AW-1:0] cfg_table_base,
  input  logic [AW-1:0] cfg_in_base,
  output logic          status_ready,
  output logic          fault_sticky,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_fault,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [63:0]   mem_rdata
);
  localparam int unsigned PW = AW - PG_SH;

  logic [AW-1:0]    in_off;
  logic             below, fire, pg_hit, w_start, w_busy, w_done, w_fault, flt_ev;
  logic [PW-1:0]    hit_pg, w_page, pn_q;
  logic [PG_SH-1:0] lo_q;

  assign in_off       = req_addr - cfg_in_base;
  assign below        = req_addr < cfg_in_base;
  assign status_ready = !w_busy;
  assign req_ready    = cfg_enable && status_ready;
  assign fire         = req_valid && req_ready;
  assign w_start      = fire && cfg_translate && !below && !pg_hit;
  assign flt_ev       = (fire && cfg_translate && below) || (w_done && w_fault);

  cx_walker #(.AW(AW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (cfg_enable),
    .start      (w_start),
    .tgt_tbl    (in_off[AW-1:TBL_SH]),
    .tgt_idx    (in_off[TBL_SH-1:PG_SH]),
    .tbl_base   (cfg_table_base),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (w_busy),
    .done       (w_done),
    .done_fault (w_fault),
    .done_page  (w_page)
  );

  cx_page_cache #(.PW(PW)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_enable),
    .look_pn (in_off[AW-1:PG_SH]),
    .hit     (pg_hit),
    .hit_pg  (hit_pg),
    .fill    (w_done && !w_fault),
    .fill_pn (pn_q),
    .fill_pg (w_page)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_addr     <= '0;
      rsp_fault    <= 1'b0;
      fault_sticky <= 1'b0;
      pn_q         <= '0;
      lo_q         <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      if (fire) begin
        pn_q <= in_off[AW-1:PG_SH];
        lo_q <= in_off[PG_SH-1:0];
        if (!cfg_translate) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= req_addr;
        end else if (below) begin
          rsp_valid <= 1'b1;
          rsp_fault <= 1'b1;
          rsp_addr  <= '0;
        end else if (pg_hit) begin
          rsp_valid <= 1'b1;
          rsp_addr  <= {hit_pg, in_off[PG_SH-1:0]};
        end
      end
      if (w_done) begin
        rsp_valid <= 1'b1;
        rsp_fault <= w_fault;
        rsp_addr  <= w_fault ? '0 : {w_page, lo_q};
      end
      if (flt_ev)           fault_sticky <= 1'b1;
      else if (!cfg_enable) fault_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/cx_checks.sv
`timescale 1ns/1ps
module cx_checks #(
  parameter int unsigned AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          cfg_translate,
  input logic [AW-1:0] cfg_in_base,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_addr,
  input logic          rsp_fault,
  input logic          fault_sticky,
  input logic          status_ready,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          w_start
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cfg_translate |=> rsp_valid && !rsp_fault && (rsp_addr == $past(req_addr)));

  assert_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cfg_translate && (req_addr < cfg_in_base) |=> rsp_valid && rsp_fault);

  assert_nowalk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cfg_translate && (req_addr < cfg_in_base) |-> !w_start);

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> fault_sticky);

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_sticky && cfg_enable |=> fault_sticky);

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cfg_enable && status_ready);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    w_start |=> !status_ready);

  assert_rd_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !status_ready);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[2:0] == 3'b000));
endmodule

bind chain_xlate cx_checks #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .cfg_translate(cfg_translate),
  .cfg_in_base  (cfg_in_base),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_addr     (rsp_addr),
  .rsp_fault    (rsp_fault),
  .fault_sticky (fault_sticky),
  .status_ready (status_ready),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .w_start      (w_start)
);

// File: tb/sim_chain_xlate.sv
`timescale 1ns/1ps
module sim_chain_xlate;
  localparam int AW = 40;
  localparam logic [AW-1:0] INB  = 40'h00_0010_0000;
  localparam logic [AW-1:0] DATA = 40'h20_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_translate = 1'b0;
  logic [AW-1:0] cfg_table_base = '0, cfg_in_base = '0;
  logic status_ready, fault_sticky, req_ready, rsp_valid, rsp_fault, mem_req;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] rsp_addr, mem_addr;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  chain_xlate #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_translate(cfg_translate),
    .cfg_table_base(cfg_table_base), .cfg_in_base(cfg_in_base),
    .status_ready(status_ready), .fault_sticky(fault_sticky),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int n_chk = 0, n_bad = 0;
  logic [63:0] mem [logic [AW-1:0]];
  logic [AW-1:0] tbl [3];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [AW-1:0] pg(input int t, input int i);
    return DATA + (AW'(t) << 24) + (AW'(i) << 12);
  endfunction

  function automatic logic [AW-1:0] ia(input int t, input int i, input int lo);
    return INB + (AW'(t) << 20) + (AW'(i) << 12) + AW'(lo);
  endfunction

  // memory responder with programmable latency
  int lat = 3, cnt = 0;
  bit pend = 0;
  logic [AW-1:0] paddr;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(paddr);
        pend = 0;
      end
    end
    if (mem_req) begin
      pend = 1; cnt = lat; paddr = mem_addr;
    end
  end

  // behavioural reference state
  bit m_cv = 0, m_pv = 0, m_sticky = 0;
  longint m_ct = 0;
  logic [AW-1:0] m_ctaddr = '0;
  logic [AW-13:0] m_pn = '0, m_page = '0;
  logic [AW-1:0] q_addr[$];
  bit q_f[$], q_st[$];
  int q_r[$];
  string q_tag[$];

  task automatic model(input logic [AW-1:0] a, output logic [AW-1:0] ea,
                       output bit ef, output int er);
    logic [AW-1:0] off;
    logic [63:0] e;
    longint tn;
    bit fwd = 0;
    ea = '0; ef = 0; er = 0;
    if (!cfg_translate) begin ea = a; return; end
    if (a < cfg_in_base) begin ef = 1; return; end
    off = a - cfg_in_base;
    tn = longint'(off >> 20);
    if (m_pv && (off[AW-1:12] == m_pn)) begin ea = {m_page, off[11:0]}; return; end
    forever begin
      if (m_cv && tn == m_ct) begin
        er++;
        e = rd(m_ctaddr + AW'(off[19:12]) * 8);
        if (!e[0]) ef = 1;
        else begin
          m_pv = 1; m_pn = off[AW-1:12]; m_page = e[AW-1:12];
          ea = {m_page, off[11:0]};
        end
        break;
      end else if (m_cv && (tn == m_ct + 1 || (fwd && tn > m_ct))) begin
        er++;
        e = rd(m_ctaddr + AW'(12'hFF8));
        if (!e[0]) begin ef = 1; break; end
        m_ctaddr = {e[AW-1:12], 12'h000}; m_ct++;
      end else if (m_cv && tn + 1 == m_ct) begin
        er++;
        e = rd(m_ctaddr + AW'(12'hFF0));
        if (!e[0]) begin ef = 1; break; end
        m_ctaddr = {e[AW-1:12], 12'h000}; m_ct--;
      end else begin
        m_cv = 1; m_ct = 0; m_ctaddr = cfg_table_base; fwd = 1;
      end
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input string tag);
    logic [AW-1:0] ea;
    bit ef;
    int er;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model(a, ea, ef, er);
    if (ef) m_sticky = 1;
    q_addr.push_back(ea); q_f.push_back(ef); q_r.push_back(er);
    q_st.push_back(m_sticky); q_tag.push_back(tag);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (er == 0) chk(rsp_valid === 1'b1, tag, "next-cycle response", 64'(rsp_valid), 64'h1);
    while (q_addr.size() != 0) @(negedge clk);
  endtask

  // per-clock monitor against the reference queue
  int rd_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        rd_cnt++;
        chk(status_ready === 1'b0, "R10", "ready during walk", 64'(status_ready), 64'h0);
        chk(mem_addr[2:0] == 3'b000, "R11", "read alignment", 64'(mem_addr), 64'h0);
      end
      if (rsp_valid) begin
        if (q_addr.size() == 0) chk(1'b0, "R13", "unexpected response", 64'(rsp_addr), 64'h0);
        else begin
          logic [AW-1:0] ea;
          bit ef, es;
          int er;
          string tg;
          ea = q_addr.pop_front(); ef = q_f.pop_front(); er = q_r.pop_front();
          es = q_st.pop_front(); tg = q_tag.pop_front();
          chk(rsp_fault === ef, tg, "fault", 64'(rsp_fault), 64'(ef));
          if (!ef) chk(rsp_addr === ea, tg, "address", 64'(rsp_addr), 64'(ea));
          chk(rd_cnt == er, tg, "memory reads", 64'(rd_cnt), 64'(er));
          chk(fault_sticky === es, "R9", "sticky flag", 64'(fault_sticky), 64'(es));
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tbl[0] = 40'h0A_0000_0000; tbl[1] = 40'h0A_0000_3000; tbl[2] = 40'h0A_0000_7000;
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 256; i++)
        if (!(t == 1 && i == 5) && !(t == 2 && i >= 16))
          mem[tbl[t] + AW'(i * 8)] = {24'h0, pg(t, i)} | 64'h1;
    mem[tbl[0] + AW'(8)]     = {24'h0, pg(0, 1)} | 64'hFF1;  // junk in bits 11:1
    mem[tbl[0] + AW'(12'hFF8)] = {24'h0, tbl[1]} | 64'h1;
    mem[tbl[1] + AW'(12'hFF0)] = {24'h0, tbl[0]} | 64'h1;
    mem[tbl[1] + AW'(12'hFF8)] = {24'h0, tbl[2]} | 64'h1;
    mem[tbl[2] + AW'(12'hFF0)] = {24'h0, tbl[1]} | 64'h1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R13", "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(mem_req === 1'b0, "R11", "reset mem_req", 64'(mem_req), 64'h0);
    chk(fault_sticky === 1'b0, "R9", "reset sticky", 64'(fault_sticky), 64'h0);
    chk(status_ready === 1'b1, "R10", "reset ready", 64'(status_ready), 64'h1);
    chk(req_ready === 1'b0, "R10", "req_ready while disabled", 64'(req_ready), 64'h0);

    cfg_table_base = tbl[0]; cfg_in_base = INB; cfg_enable = 1'b1;
    send(40'h12_3456_789A, "R1");
    send(40'h00_0000_0040, "R1");          // below base still forwarded

    cfg_translate = 1'b1;
    send(ia(0, 0, 12'h123), "R5");         // restart then entry
    send(ia(0, 0, 12'h456), "R8");         // same page, cached
    send(ia(0, 7, 12'h008), "R2");
    send(ia(1, 5, 12'h010), "R3");         // next link, invalid entry
    send(ia(1, 6, 12'h020), "R2");
    send(ia(0, 3, 12'h030), "R4");         // previous link
    send(ia(2, 2, 12'h040), "R5");         // jump of two tables
    send(ia(2, 20, 12'h050), "R3");        // unused slot of last table
    send(ia(3, 0, 12'h060), "R6");         // cleared next link
    send(ia(2, 1, 12'h070), "R6");         // still on table 2
    send(40'h00_0005_0000, "R7");
    lat = 1;
    send(ia(1, 9, 12'h080), "R11");
    lat = 7;
    send(ia(0, 1, 12'hABC), "R2");         // junk bits 11:1 ignored

    @(negedge clk); cfg_enable = 1'b0;
    m_sticky = 0; m_cv = 0; m_pv = 0;
    @(negedge clk); @(negedge clk);
    chk(fault_sticky === 1'b0, "R9", "cleared when disabled", 64'(fault_sticky), 64'h0);
    chk(req_ready === 1'b0, "R10", "no accept when disabled", 64'(req_ready), 64'h0);
    cfg_enable = 1'b1;
    send(ia(0, 1, 12'h111), "R12");        // cache dropped: walk again
    send(ia(2, 0, 12'h222), "R12");
    send(ia(0, 200, 12'h333), "R5");       // backward jump restarts

    repeat (4) @(negedge clk);
    chk(q_addr.size() == 0, "R13", "outstanding responses", 64'(q_addr.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule